// File: doc/BRIEF.md
# Command-Buffer SPI Transfer Sequencer

This block is an SPI master engine that runs a whole transfer from a shared byte buffer. Software (or another block) fills the buffer through a simple host port: a two-byte header at the start, stored high byte first, followed by the bytes to send. A command word then starts the engine, either at once or on the next external trigger pulse, and also picks a timing profile index and one of the slave-select lines.

Once started, the engine reads and decodes the header. It then moves the requested number of bytes over the serial pins, MSB first, on one data line or on two. Transmit bytes come from the buffer past the header, and received bytes are written back from offset zero. While it runs it reports busy. At the end it sets a done flag, or an invalid-control flag if the header cannot be run. Halt and flush commands stop a running transfer. The serial bit rate comes from an external single-cycle tick, so the engine holds no clock divider.

Top module: `spi_cmd_seq`

## Requirements
- R1: The host port writes the buffer on `host_we` and returns the byte at `host_addr` on `host_rdata` one cycle later while the engine is idle. Host writes made while `busy` is high are dropped.
- R2: `cmd_word` bits 3:0 hold the action (0 none, 1 start now, 2 start on trigger, 3 halt, 4 flush), bits 11:8 the profile index and bits 14:12 the select line. A start is accepted only when idle, and `prof_sel` then holds the accepted profile until the next accepted start.
- R3: The header is buffer byte 0 (high) and byte 1 (low). Header bits 15:13 give the operation (0 sleep, 1 read and write, 2 write, 3 read, 4 set interrupt), bit 11 selects two-line data, and bits 9:0 give the byte count.
- R4: Write and read-and-write operations send buffer bytes from offset 2, MSB first, on `spi_mosi[0]` in SPI mode 0. The data changes while `spi_sclk` is low, a slave samples it on the rising edge, and `spi_sclk` rests low whenever not busy.
- R5: Read and read-and-write operations sample `spi_miso[0]` on each rising edge and store byte n of the received data at buffer offset n.
- R6: With header bit 11 set, a write or read operation moves two bits per clock, four clocks per byte, with the higher bit on line 1 of the pair. For read-and-write the bit is ignored and one line is used.
- R7: Each `spi_cs` line rests at the inverse of its `cs_pol` bit, where a 1 means active-high. Only the selected line is driven to its active level, and only while bytes are moving.
- R8: `busy` rises the cycle after a start is accepted and falls when the command ends. `stat_done` is set on the same edge that `busy` falls after a normal finish. A sleep, set-interrupt or zero-count header finishes with no serial clocks. Both status flags clear when the next start is accepted.
- R9: An operation code above 4, or a count above 510 for the transmitting operations or above 512 for a read, sets `stat_inval`, leaves `stat_done` clear and produces no serial clock.
- R10: Halt while busy ends the transfer at the next byte boundary with `stat_done` clear. Halt while idle has no effect.
- R11: Flush while busy returns the engine to idle on the next edge with `spi_sclk` low, the select lines released and `stat_done` clear.
- R12: Start on trigger holds `busy` high with no serial clock until `trig` is sampled high, then runs the transfer.
- R13: `spi_sclk` changes only on a cycle where `tick` is high, except when a flush forces it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host buffer write strobe |
| host_addr | input | 9 | Host buffer byte address |
| host_wdata | input | 8 | Host buffer write byte |
| host_rdata | output | 8 | Buffer read byte, one cycle after the address |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 16 | Action, profile index and select line |
| trig | input | 1 | External start pulse for start-on-trigger |
| tick | input | 1 | Serial half-period enable |
| cs_pol | input | 8 | Active level of each select line |
| busy | output | 1 | Command executing |
| stat_done | output | 1 | Sticky command-complete flag |
| stat_inval | output | 1 | Sticky invalid-control flag |
| prof_sel | output | 4 | Profile index of the accepted command |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 2 | Serial data out (line 0 for single-line mode) |
| spi_miso | input | 2 | Serial data in (line 0 for single-line mode) |
| spi_cs | output | 8 | Slave-select lines |

## Verification
The transfer path is driven in four forms: single-line write, single-line read, read-and-write, and two-line read or write, with random counts, select lines, polarities and tick densities. Comparing the serial bit stream with buffer offset 2 onward shows whether the header offset and bit order are right. Reading back the buffer against the slave's bytes shows where received data lands. Counting rising edges tells one-line from two-line framing. Directed cases cover the length limits on each side of 510 and 512, an undefined opcode, halt and flush in mid-byte, a start held for a trigger, and host or command traffic arriving while busy.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    // header layout (16 bits, high byte stored at buffer offset 0)
    localparam int HDR_BYTES = 2;
    localparam int LEN_W     = 10;

    localparam logic [2:0] OPC_SLEEP = 3'd0;
    localparam logic [2:0] OPC_XFER  = 3'd1;
    localparam logic [2:0] OPC_WR    = 3'd2;
    localparam logic [2:0] OPC_RD    = 3'd3;
    localparam logic [2:0] OPC_IRQ   = 3'd4;

    localparam logic [3:0] ACT_NONE  = 4'd0;
    localparam logic [3:0] ACT_GO    = 4'd1;
    localparam logic [3:0] ACT_ARM   = 4'd2;
    localparam logic [3:0] ACT_STOP  = 4'd3;
    localparam logic [3:0] ACT_PURGE = 4'd4;

    typedef struct packed {
        logic [2:0]       op;
        logic             rsv12;
        logic             two_line;
        logic             rsv10;
        logic [LEN_W-1:0] len;
    } hdr_t;

    typedef struct packed {
        logic       rsv15;
        logic [2:0] sel;
        logic [3:0] prof;
        logic [3:0] rsv;
        logic [3:0] act;
    } cmdw_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ARMED, ST_HDR0, ST_HDR1, ST_DEC,
        ST_FETCH, ST_LOAD, ST_SHIFT, ST_STORE, ST_END
    } seq_st_e;

    function automatic logic op_sends(input logic [2:0] op);
        return (op == OPC_XFER) || (op == OPC_WR);
    endfunction

    function automatic logic op_takes(input logic [2:0] op);
        return (op == OPC_XFER) || (op == OPC_RD);
    endfunction

    function automatic logic hdr_legal(input hdr_t h, input int buf_bytes);
        int room;
        if (h.op > OPC_IRQ) return 1'b0;
        room = op_sends(h.op) ? buf_bytes - HDR_BYTES : buf_bytes;
        if ((op_sends(h.op) || op_takes(h.op)) && (int'(h.len) > room)) return 1'b0;
        return 1'b1;
    endfunction

endpackage

// File: rtl/seq_buffer.sv
module seq_buffer #(
    parameter int DEPTH = 512,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end
endmodule

// File: rtl/seq_shifter.sv
module seq_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          abort,
    input  logic          load,
    input  logic [DW-1:0] load_byte,
    input  logic          two_line,
    input  logic          tick,
    input  logic [1:0]    miso,
    output logic          sclk,
    output logic [1:0]    mosi,
    output logic [DW-1:0] rx_byte,
    output logic          byte_done
);
    localparam int CW = $clog2(DW);

    logic [DW-1:0] sh;
    logic [CW-1:0] cnt;
    logic          phase, active, dual_q;
    logic [CW-1:0] last;

    assign last = dual_q ? CW'(DW/2 - 1) : CW'(DW - 1);
    assign mosi = dual_q ? sh[DW-1 -: 2] : {1'b0, sh[DW-1]};

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            sh <= '0; rx_byte <= '0; cnt <= '0;
            phase <= 1'b0; active <= 1'b0; dual_q <= 1'b0;
            sclk <= 1'b0; byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (load) begin
                sh      <= load_byte;
                rx_byte <= '0;
                cnt     <= '0;
                phase   <= 1'b0;
                active  <= 1'b1;
                dual_q  <= two_line;
                sclk    <= 1'b0;
            end else if (active && tick) begin
                if (!phase) begin
                    sclk    <= 1'b1;
                    phase   <= 1'b1;
                    rx_byte <= dual_q ? {rx_byte[DW-3:0], miso} : {rx_byte[DW-2:0], miso[0]};
                end else begin
                    sclk  <= 1'b0;
                    phase <= 1'b0;
                    sh    <= dual_q ? {sh[DW-3:0], 2'b00} : {sh[DW-2:0], 1'b0};
                    cnt   <= cnt + 1'b1;
                    if (cnt == last) begin
                        active    <= 1'b0;
                        byte_done <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_seq_pkg::*;
#(
    parameter int BUF_BYTES = 512,
    parameter int NUM_CS    = 8,
    localparam int AW       = $clog2(BUF_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              cmd_valid,
    input  logic [15:0]       cmd_word,
    input  logic              trig,
    input  logic              tick,
    input  logic [NUM_CS-1:0] cs_pol,
    output logic              busy,
    output logic              stat_done,
    output logic              stat_inval,
    output logic [3:0]        prof_sel,
    output logic              spi_sclk,
    output logic [1:0]        spi_mosi,
    input  logic [1:0]        spi_miso,
    output logic [NUM_CS-1:0] spi_cs
);
    localparam int SW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

    seq_st_e          st;
    cmdw_t            cw;
    hdr_t             hdr_q, hdr_w;
    logic [7:0]       hdr_hi;
    logic [LEN_W-1:0] idx, idx_nx, tx_off;
    logic [SW-1:0]    sel_q;
    logic             halt_pend, idle, lines_on;
    logic             go_now, go_arm, stop_req, purge_req;

    logic             mem_we;
    logic [AW-1:0]    mem_addr;
    logic [7:0]       mem_wdata, mem_rdata;

    logic             sh_load, sh_done, sh_dual;
    logic [7:0]       sh_rx, sh_byte;

    assign cw        = cmdw_t'(cmd_word);
    assign idle      = (st == ST_IDLE);
    assign go_now    = cmd_valid && (cw.act == ACT_GO);
    assign go_arm    = cmd_valid && (cw.act == ACT_ARM);
    assign stop_req  = cmd_valid && (cw.act == ACT_STOP);
    assign purge_req = cmd_valid && (cw.act == ACT_PURGE) && !idle;
    assign hdr_w     = hdr_t'({hdr_hi, mem_rdata});
    assign idx_nx    = idx + 1'b1;
    assign tx_off    = idx + LEN_W'(HDR_BYTES);

    // buffer port: host owns it when idle, engine otherwise
    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = host_addr;
        mem_wdata = host_wdata;
        if (idle) begin
            mem_we = host_we;
        end else begin
            unique case (st)
                ST_HDR0:  mem_addr = AW'(0);
                ST_HDR1:  mem_addr = AW'(1);
                ST_FETCH: mem_addr = tx_off[AW-1:0];
                ST_STORE: begin
                    mem_addr  = idx[AW-1:0];
                    mem_we    = op_takes(hdr_q.op);
                    mem_wdata = sh_rx;
                end
                default:  mem_addr = AW'(0);
            endcase
        end
    end

    seq_buffer #(.DEPTH(BUF_BYTES), .DW(8)) u_buf (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );
    assign host_rdata = mem_rdata;

    assign sh_load = (st == ST_LOAD);
    assign sh_byte = op_sends(hdr_q.op) ? mem_rdata : 8'h00;
    assign sh_dual = hdr_q.two_line && ((hdr_q.op == OPC_WR) || (hdr_q.op == OPC_RD));

    seq_shifter #(.DW(8)) u_sh (
        .clk       (clk),
        .rst       (rst),
        .abort     (purge_req),
        .load      (sh_load),
        .load_byte (sh_byte),
        .two_line  (sh_dual),
        .tick      (tick),
        .miso      (spi_miso),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi),
        .rx_byte   (sh_rx),
        .byte_done (sh_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            hdr_hi     <= '0;
            hdr_q      <= '0;
            idx        <= '0;
            sel_q      <= '0;
            prof_sel   <= '0;
            halt_pend  <= 1'b0;
            stat_done  <= 1'b0;
            stat_inval <= 1'b0;
        end else if (purge_req) begin
            st        <= ST_IDLE;
            idx       <= '0;
            halt_pend <= 1'b0;
        end else begin
            if (!idle && stop_req) halt_pend <= 1'b1;
            unique case (st)
                ST_IDLE: begin
                    halt_pend <= 1'b0;
                    if (go_now || go_arm) begin
                        sel_q      <= SW'(cw.sel);
                        prof_sel   <= cw.prof;
                        stat_done  <= 1'b0;
                        stat_inval <= 1'b0;
                        idx        <= '0;
                        st         <= go_now ? ST_HDR0 : ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (stop_req || halt_pend) st <= ST_IDLE;
                    else if (trig)             st <= ST_HDR0;
                end
                ST_HDR0: st <= ST_HDR1;
                ST_HDR1: begin
                    hdr_hi <= mem_rdata;
                    st     <= ST_DEC;
                end
                ST_DEC: begin
                    hdr_q <= hdr_w;
                    if (stop_req || halt_pend) begin
                        st <= ST_IDLE;
                    end else if (!hdr_legal(hdr_w, BUF_BYTES)) begin
                        stat_inval <= 1'b1;
                        st         <= ST_IDLE;
                    end else if (!(op_sends(hdr_w.op) || op_takes(hdr_w.op)) || hdr_w.len == '0) begin
                        st <= ST_END;
                    end else begin
                        st <= ST_FETCH;
                    end
                end
                ST_FETCH: st <= ST_LOAD;
                ST_LOAD:  st <= ST_SHIFT;
                ST_SHIFT: if (sh_done) st <= ST_STORE;
                ST_STORE: begin
                    idx <= idx_nx;
                    if (idx_nx == hdr_q.len)          st <= ST_END;
                    else if (stop_req || halt_pend)   st <= ST_IDLE;
                    else                              st <= ST_FETCH;
                end
                ST_END: begin
                    stat_done <= 1'b1;
                    st        <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy     = !idle;
    assign lines_on = (st == ST_FETCH) || (st == ST_LOAD) || (st == ST_SHIFT) || (st == ST_STORE);

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign spi_cs[g] = (lines_on && (sel_q == SW'(g))) ? cs_pol[g] : ~cs_pol[g];
    end
endmodule

// File: rtl/spi_cmd_seq_chk.sv
module spi_cmd_seq_chk #(
    parameter int NUM_CS = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              stat_done,
    input logic              stat_inval,
    input logic [3:0]        prof_sel,
    input logic              spi_sclk,
    input logic [NUM_CS-1:0] spi_cs,
    input logic [NUM_CS-1:0] cs_pol,
    input logic              cmd_valid,
    input logic [15:0]       cmd_word,
    input logic              tick
);
    logic purge_cmd;
    assign purge_cmd = cmd_valid && (cmd_word[3:0] == 4'd4);

    // R7
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~(spi_cs ^ cs_pol)));

    // R7
    cs_rest_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (spi_cs == ~cs_pol));

    // R4
    sclk_rest_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !spi_sclk);

    // R13
    sclk_pace_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !purge_cmd) |=> $stable(spi_sclk));

    // R8
    done_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_done) |-> $fell(busy));

    // R9
    inval_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_inval) |-> !stat_done);

    // R11
    purge_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && purge_cmd) |=> (!busy && !spi_sclk));

    // R2
    prof_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(prof_sel));
endmodule

bind spi_cmd_seq spi_cmd_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .stat_done  (stat_done),
    .stat_inval (stat_inval),
    .prof_sel   (prof_sel),
    .spi_sclk   (spi_sclk),
    .spi_cs     (spi_cs),
    .cs_pol     (cs_pol),
    .cmd_valid  (cmd_valid),
    .cmd_word   (cmd_word),
    .tick       (tick)
);

// File: tb/tb_spi_cmd_seq.sv
module tb_spi_cmd_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_we;
    logic [8:0]  host_addr;
    logic [7:0]  host_wdata, host_rdata;
    logic        cmd_valid;
    logic [15:0] cmd_word;
    logic        trig, tick;
    logic [7:0]  cs_pol;
    logic        busy, stat_done, stat_inval;
    logic [3:0]  prof_sel;
    logic        spi_sclk;
    logic [1:0]  spi_mosi, spi_miso;
    logic [7:0]  spi_cs;

    spi_cmd_seq dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .cmd_valid(cmd_valid),
        .cmd_word(cmd_word), .trig(trig), .tick(tick), .cs_pol(cs_pol),
        .busy(busy), .stat_done(stat_done), .stat_inval(stat_inval),
        .prof_sel(prof_sel), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs(spi_cs)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;
    bit finished = 0;
    int tick_mode = 1;          // 0 hold low, 1 always, 2 sparse

    always @(negedge clk) begin
        case (tick_mode)
            0:       tick = 1'b0;
            1:       tick = 1'b1;
            default: tick = ($urandom % 3) == 0;
        endcase
    end

    // slave model
    logic [7:0] sl_mem [0:511];
    logic [7:0] txd    [0:511];
    bit         cap    [0:8191];
    int         cap_n, edge_n, cs_bad, miso_n;
    logic       sl_dual;
    logic [7:0] exp_cs;

    function automatic logic sbit(input int n);
        if (n >= 4096) return 1'b0;
        return sl_mem[n >> 3][7 - (n & 7)];
    endfunction

    function automatic void upd_miso();
        spi_miso = sl_dual ? {sbit(miso_n), sbit(miso_n + 1)} : {1'b0, sbit(miso_n)};
    endfunction

    always @(posedge spi_sclk) begin
        edge_n++;
        if (spi_cs !== exp_cs) cs_bad++;
        if (cap_n < 8190) begin
            if (sl_dual) begin
                cap[cap_n] = spi_mosi[1]; cap[cap_n + 1] = spi_mosi[0];
                cap_n += 2; miso_n += 2;
            end else begin
                cap[cap_n] = spi_mosi[0];
                cap_n += 1; miso_n += 1;
            end
        end
        upd_miso();
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic host_wr(input int a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = 9'(a); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_rd(input int a, output logic [7:0] d);
        @(negedge clk);
        host_addr = 9'(a);
        @(negedge clk);
        d = host_rdata;
    endtask

    task automatic send_cmd(input logic [3:0] act, input logic [3:0] prof, input logic [2:0] ss);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_word = {1'b0, ss, prof, 4'h0, act};
        @(negedge clk);
        cmd_valid = 1'b0; cmd_word = '0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 30000) begin
            @(negedge clk);
            n++;
        end
    endtask

    logic [2:0] cur_op;
    int         cur_len;
    logic       cur_dual;

    // writes header and data, primes the slave, clears the capture
    task automatic setup(input logic [2:0] op, input logic dual, input int len,
                         input logic [2:0] ss, input logic [7:0] pol);
        logic [9:0] l10 = 10'(len);
        cur_op = op; cur_len = len; cur_dual = dual;
        cs_pol = pol;
        host_wr(0, {op, 1'b0, dual, 1'b0, l10[9:8]});
        host_wr(1, l10[7:0]);
        if (op == 3'd1 || op == 3'd2) begin
            for (int i = 0; i < len && i < 510; i++) begin
                txd[i] = 8'($urandom);
                host_wr(i + 2, txd[i]);
            end
        end
        for (int i = 0; i < 512; i++) sl_mem[i] = 8'($urandom);
        cap_n = 0; edge_n = 0; cs_bad = 0; miso_n = 0;
        sl_dual = dual && (op == 3'd2 || op == 3'd3);
        exp_cs = ~pol;
        exp_cs[ss] = pol[ss];
        upd_miso();
    endtask

    function automatic int tx_bad(input int nbits);
        int bad = 0;
        for (int k = 0; k < nbits; k++)
            if (cap[k] != txd[k / 8][7 - (k % 8)]) bad++;
        return bad;
    endfunction

    task automatic rx_bad(input int len, output int bad);
        logic [7:0] d;
        bad = 0;
        for (int i = 0; i < len; i++) begin
            host_rd(i, d);
            if (d !== sl_mem[i]) bad++;
        end
    endtask

    // full check of a normally finished transfer
    task automatic verify(input string tag, input logic [3:0] prof);
        int exp_edges, bad;
        bit sends, takes;
        wait_idle();
        sends = (cur_op == 3'd1 || cur_op == 3'd2);
        takes = (cur_op == 3'd1 || cur_op == 3'd3);
        exp_edges = (sends || takes) ? cur_len * (sl_dual ? 4 : 8) : 0;
        chk(stat_done === 1'b1 && stat_inval === 1'b0, {tag, " R8 done flag"}, int'(stat_done), 1);
        chk(edge_n == exp_edges, {tag, " R6 clock count"}, edge_n, exp_edges);
        if (sends) chk(tx_bad(cur_len * 8) == 0, {tag, " R4 sent bits"}, tx_bad(cur_len * 8), 0);
        if (takes) begin
            rx_bad(cur_len, bad);
            chk(bad == 0, {tag, " R5 stored bytes"}, bad, 0);
        end
        chk(cs_bad == 0, {tag, " R7 select level"}, cs_bad, 0);
        chk(prof_sel == prof, {tag, " R2 profile"}, int'(prof_sel), int'(prof));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int e0;
        void'($urandom(32'd7321));
        rst = 1'b1; host_we = 0; host_addr = 0; host_wdata = 0;
        cmd_valid = 0; cmd_word = 0; trig = 0; cs_pol = 8'h05;
        sl_dual = 0; miso_n = 0; spi_miso = 2'b00; exp_cs = 8'hFA;
        cap_n = 0; edge_n = 0; cs_bad = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state (R8, R7, R4)
        chk(busy === 0 && stat_done === 0 && stat_inval === 0, "R8 reset status", int'(busy), 0);
        chk(spi_cs === ~cs_pol && spi_sclk === 0, "R7 reset select", int'(spi_cs), int'(~cs_pol));

        // R1 host access
        host_wr(5, 8'hA7);
        host_rd(5, d);
        chk(d === 8'hA7, "R1 host readback", int'(d), 'hA7);

        // R10 halt while idle has no effect
        send_cmd(4'd3, 4'd0, 3'd0);
        chk(busy === 0, "R10 halt idle", int'(busy), 0);

        // directed transfers
        tick_mode = 1;
        setup(3'd2, 0, 5, 3'd2, 8'h00);  send_cmd(4'd1, 4'd3, 3'd2);  verify("R4 write", 4'd3);
        tick_mode = 2;
        setup(3'd3, 0, 7, 3'd5, 8'hA0);  send_cmd(4'd1, 4'd6, 3'd5);  verify("R5 read", 4'd6);
        setup(3'd1, 0, 12, 3'd0, 8'hFF); send_cmd(4'd1, 4'd1, 3'd0);  verify("R5 rw", 4'd1);
        tick_mode = 1;
        setup(3'd2, 1, 6, 3'd7, 8'h81);  send_cmd(4'd1, 4'd2, 3'd7);  verify("R6 dual write", 4'd2);
        setup(3'd3, 1, 9, 3'd1, 8'h02);  send_cmd(4'd1, 4'd4, 3'd1);  verify("R6 dual read", 4'd4);
        setup(3'd1, 1, 4, 3'd3, 8'h00);  send_cmd(4'd1, 4'd5, 3'd3);  verify("R6 rw ignores dual", 4'd5);

        // R3/R9 length boundaries that are legal
        setup(3'd2, 0, 510, 3'd4, 8'h10); send_cmd(4'd1, 4'd7, 3'd4); verify("R9 write 510", 4'd7);
        setup(3'd3, 1, 512, 3'd6, 8'h00); send_cmd(4'd1, 4'd8, 3'd6); verify("R9 read 512", 4'd8);

        // R9 illegal headers
        setup(3'd2, 0, 511, 3'd0, 8'h00); send_cmd(4'd1, 4'd0, 3'd0); wait_idle();
        chk(stat_inval === 1 && stat_done === 0 && edge_n == 0, "R9 write 511", int'(stat_inval), 1);
        setup(3'd3, 0, 513, 3'd0, 8'h00); send_cmd(4'd1, 4'd0, 3'd0); wait_idle();
        chk(stat_inval === 1 && stat_done === 0 && edge_n == 0, "R9 read 513", int'(stat_inval), 1);
        setup(3'd5, 0, 3, 3'd0, 8'h00);   send_cmd(4'd1, 4'd0, 3'd0); wait_idle();
        chk(stat_inval === 1 && stat_done === 0 && edge_n == 0, "R9 opcode 5", int'(stat_inval), 1);

        // R8 no-transfer operations, status cleared by next start
        setup(3'd0, 0, 9, 3'd0, 8'h00); send_cmd(4'd1, 4'd9, 3'd0);
        chk(stat_inval === 0, "R8 inval cleared by start", int'(stat_inval), 0);
        verify("R8 sleep", 4'd9);
        setup(3'd4, 0, 2, 3'd0, 8'h00); send_cmd(4'd1, 4'd9, 3'd0); verify("R8 set irq", 4'd9);
        setup(3'd2, 0, 0, 3'd0, 8'h00); send_cmd(4'd1, 4'd9, 3'd0); verify("R8 zero count", 4'd9);

        // R2 start while busy ignored, R1 host write while busy dropped
        host_wr(300, 8'hC3);
        setup(3'd2, 0, 8, 3'd1, 8'h00); send_cmd(4'd1, 4'd10, 3'd1);
        send_cmd(4'd1, 4'd12, 3'd6);
        host_wr(300, 8'h5A);
        verify("R2 start while busy", 4'd10);
        host_rd(300, d);
        chk(d === 8'hC3, "R1 write while busy", int'(d), 'hC3);

        // R13 no clock while tick low
        tick_mode = 0;
        setup(3'd2, 0, 4, 3'd2, 8'h00); send_cmd(4'd1, 4'd1, 3'd2);
        repeat (40) @(negedge clk);
        chk(busy === 1 && edge_n == 0, "R13 tick held low", edge_n, 0);
        tick_mode = 1;
        verify("R13 resume", 4'd1);

        // R10 halt mid-transfer
        setup(3'd2, 0, 20, 3'd3, 8'h00); send_cmd(4'd1, 4'd2, 3'd3);
        while (edge_n < 20) @(negedge clk);
        send_cmd(4'd3, 4'd0, 3'd0);
        wait_idle();
        e0 = edge_n;
        chk(e0 % 8 == 0 && e0 >= 24 && e0 < 160 && stat_done === 0, "R10 halt boundary", e0, 24);
        chk(tx_bad(e0) == 0, "R10 halted bits", tx_bad(e0), 0);

        // R11 flush mid-byte
        tick_mode = 2;
        setup(3'd3, 0, 20, 3'd4, 8'h3C); send_cmd(4'd1, 4'd2, 3'd4);
        while (edge_n < 13) @(negedge clk);
        send_cmd(4'd4, 4'd0, 3'd0);
        chk(busy === 0 && spi_sclk === 0 && spi_cs === ~cs_pol && stat_done === 0,
            "R11 flush", int'(busy), 0);
        setup(3'd3, 0, 3, 3'd4, 8'h3C); send_cmd(4'd1, 4'd2, 3'd4); verify("R11 after flush", 4'd2);

        // R12 start on trigger
        tick_mode = 1;
        setup(3'd1, 0, 5, 3'd6, 8'h40); send_cmd(4'd2, 4'd11, 3'd6);
        repeat (30) @(negedge clk);
        chk(busy === 1 && edge_n == 0, "R12 waiting", edge_n, 0);
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        verify("R12 triggered", 4'd11);

        // random transfers
        for (int it = 0; it < 8; it++) begin
            logic [2:0] op  = 3'(1 + ($urandom % 3));
            logic       dl  = 1'($urandom);
            int         len = 1 + ($urandom % 40);
            logic [2:0] ss  = 3'($urandom);
            logic [3:0] pf  = 4'($urandom);
            tick_mode = 1 + ($urandom % 2);
            setup(op, dl, len, ss, 8'($urandom));
            send_cmd(4'd1, pf, ss);
            verify("R4 random", pf);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule